// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block is a register-mapped MDIO master for indirect Clause 45 access to PHY registers. A host programs the target register number into an address register and selects an MDC rate in a configuration register. It then writes one command word into the management register. That word carries the port address, the device address, the opcode and, for a write, the data.

Each accepted command produces two MDIO frames with no gap between them. The first is an address frame that carries the register number. The second is a write frame or a read frame addressed to the same port and device. A busy flag covers both frames. When a read completes with a valid turnaround from the PHY, a read-valid flag is set and the PHY's data appears in the low half of the management register. MDC runs only while a command is in flight, at the core clock divided by 256, 64, 32 or 8.

Top module: `mdio45_master`

## Requirements
- R1: After reset, offsets 0x0, 0x8 and 0xC all read 0. MDC is low, `mdio_oe` is low and `mdio_o` is high.
- R2: Offset 0x8 stores bits 15:0 of a write and reads them back with bits 31:16 as zero. Offset 0xC stores and returns all 32 written bits. Any other offset reads 0.
- R3: A command sends two frames of 64 bits each, back to back and MSB first. Each frame has 32 ones, then start 00, then a 2-bit opcode, then the port address (5 bits), then the device address (5 bits), then turnaround 10, then 16 data bits. The first frame uses opcode 00 and carries the register number. The second frame uses opcode 01 for a write or 11 for a read, and a write frame carries the write data. Each `mdio_o` bit changes only on a falling MDC edge.
- R4: A command is accepted when it is written to offset 0x0 while idle with an opcode field (bits 28:26) of 5 (write) or 7 (read). Bits 25:21 are the device address, bits 20:16 are the port address and bits 15:0 are the data. Acceptance clears read-valid (bit 29). A read that completes with a good turnaround sets read-valid and puts the 16 bits taken from the PHY into bits 15:0, MSB first.
- R5: Busy (bit 30 of offset 0x0) reads 1 from the cycle after acceptance. It clears exactly 128 MDC periods after acceptance, which is at the end of the last data bit.
- R6: The low 2 bits of offset 0xC select the MDC period in core cycles: 0 gives 256, 1 gives 64, 2 gives 32 and 3 gives 8. MDC is low for the first half of each period and high for the second half, and it is low whenever the block is idle.
- R7: On a read, `mdio_i` is sampled at the rising MDC edge of the second turnaround bit. If it is not 0, the command still ends on time, read-valid stays 0 and bits 15:0 keep the value written with the command.
- R8: A write to offset 0x0 whose opcode field is neither 5 nor 7 has no effect: no frame starts and the register content does not change.
- R9: While busy, writes to offsets 0x0, 0x8 and 0xC have no effect.
- R10: In the second frame of a read, `mdio_oe` is 0 for both turnaround bits and all 16 data bits. It is 1 for every other bit of a command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 4 | Register byte offset (0x0, 0x8, 0xC) |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed register, combinational |
| mdc | output | 1 | MDIO management clock |
| mdio_o | output | 1 | MDIO data driven by the master |
| mdio_oe | output | 1 | Drive enable for `mdio_o` |
| mdio_i | input | 1 | MDIO data seen at the pin |

## Verification
Register reads are combinational, so the bench samples `reg_rdata` a nanosecond after it changes the address. Busy is due in the cycle after the accepting edge. When e cycles have passed since acceptance, the bench expects MDC high when e mod ratio is at least half the ratio, expects bit floor(e/ratio) on the pin, and expects busy to fall at e = 128 × ratio. A behavioural model tracks e from the accepting edge and compares MDC, drive enable and driven data at every falling clock edge. The stand-in PHY drives its turnaround and data bits from the same count, so a rising MDC edge always samples a settled value. Directed reads measure the busy duration for each divider code and check the register contents after each completion, after ignored writes and after a bad turnaround.

// File: rtl/mdio45_pkg.sv
// Package: shared constants and helpers for the Clause 45 MDIO master.
// Assumes byte offsets on a 4-bit register port and fixed protocol field sizes.
package mdio45_pkg;
    localparam logic [3:0] OFS_MGMT = 4'h0;
    localparam logic [3:0] OFS_ADDR = 4'h8;
    localparam logic [3:0] OFS_CFG  = 4'hC;

    localparam logic [2:0] OPC_WRITE = 3'h5;
    localparam logic [2:0] OPC_READ  = 3'h7;

    localparam int PRT_W  = 5;
    localparam int DEV_W  = 5;
    localparam int DATA_W = 16;
    localparam int MAX_HALF = 128;

    // Half MDC period, in core cycles, for a 2-bit divider code.
    function automatic int unsigned half_period(input logic [1:0] code);
        case (code)
            2'd0:    return 128;
            2'd1:    return 32;
            2'd2:    return 16;
            default: return 4;
        endcase
    endfunction
endpackage

// File: rtl/mdio45_mdc_gen.sv
// Module: MDC generator. While run is high it produces MDC at the selected
// ratio, starting low, and flags the core cycle before each rising and
// falling edge. Assumes div_code holds steady while run is high.
module mdio45_mdc_gen #(
    parameter int CNT_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] div_code,
    output logic       mdc,
    output logic       rise_o,
    output logic       fall_o
);
    import mdio45_pkg::*;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half_m1;
    logic             tc;

    // Terminal count for the current half period.
    always_comb begin
        half_m1 = CNT_W'(half_period(div_code) - 1);
        tc      = run && (cnt == half_m1);
        rise_o  = tc && !mdc;
        fall_o  = tc && mdc;
    end

    // Half-period counter and MDC toggle; parked low when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tc) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_MDC_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc); // R6
endmodule

// File: rtl/mdio45_frame_engine.sv
// Module: frame engine. On start it sends an address frame and then a
// write or read frame. Bits advance on MDC falling edges, and it samples
// the turnaround and data bits of a read on rising edges. Assumes its
// command inputs stay stable while active.
module mdio45_frame_engine #(
    parameter int PRE_LEN = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          is_read,
    input  logic [mdio45_pkg::PRT_W-1:0]  port,
    input  logic [mdio45_pkg::DEV_W-1:0]  dev,
    input  logic [mdio45_pkg::DATA_W-1:0] reg_num,
    input  logic [mdio45_pkg::DATA_W-1:0] wr_data,
    input  logic                          rise,
    input  logic                          fall,
    input  logic                          mdio_i,
    output logic                          active,
    output logic                          mdio_o,
    output logic                          mdio_oe,
    output logic                          done,
    output logic                          rd_ok,
    output logic [mdio45_pkg::DATA_W-1:0] rd_data
);
    import mdio45_pkg::*;

    localparam int WORD_W    = 32;
    localparam int FRAME_LEN = PRE_LEN + WORD_W;
    localparam int BIT_W     = $clog2(FRAME_LEN);
    localparam int TA_IDX    = PRE_LEN + 14;
    localparam int DAT_IDX   = PRE_LEN + 16;
    localparam int LAST_IDX  = FRAME_LEN - 1;

    logic             second;
    logic [BIT_W-1:0] bitcnt;
    logic [WORD_W-1:0] word;
    logic             cur_bit;
    logic             released;

    // Control word of the current frame and the bit at the current index.
    always_comb begin
        word = {2'b00,
                second ? (is_read ? 2'b11 : 2'b01) : 2'b00,
                port, dev, 2'b10,
                second ? wr_data : reg_num};
        if (int'(bitcnt) < PRE_LEN) cur_bit = 1'b1;
        else                        cur_bit = word[LAST_IDX - int'(bitcnt)];
    end

    // Pin drive: released across a read's turnaround and data bits.
    always_comb begin
        released = second && is_read && (bitcnt >= BIT_W'(TA_IDX));
        mdio_o   = active ? cur_bit : 1'b1;
        mdio_oe  = active && !released;
        done     = active && fall && second && (bitcnt == BIT_W'(LAST_IDX));
    end

    // Bit and frame sequencing on falling MDC edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            second <= 1'b0;
            bitcnt <= '0;
        end else if (start) begin
            active <= 1'b1;
            second <= 1'b0;
            bitcnt <= '0;
        end else if (active && fall) begin
            if (bitcnt == BIT_W'(LAST_IDX)) begin
                bitcnt <= '0;
                if (second) active <= 1'b0;
                second <= 1'b1;
            end else begin
                bitcnt <= bitcnt + 1'b1;
            end
        end
    end

    // Read sampling on rising MDC edges: turnaround check and data shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ok   <= 1'b0;
            rd_data <= '0;
        end else if (start) begin
            rd_ok <= 1'b0;
        end else if (active && rise && second && is_read) begin
            if (bitcnt == BIT_W'(TA_IDX + 1)) rd_ok <= !mdio_i;
            if (bitcnt >= BIT_W'(DAT_IDX))    rd_data <= {rd_data[DATA_W-2:0], mdio_i};
        end
    end

    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !active); // R9
    AST_DONE_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> second); // R3
    AST_MDIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        active && !fall |=> $stable(mdio_o)); // R3
endmodule

// File: rtl/mdio45_master.sv
// Module: Clause 45 MDIO master top. It holds the host registers, accepts
// commands and ties the MDC generator to the frame engine. Assumes
// single-cycle register writes, combinational reads and an external
// pull-up on MDIO.
module mdio45_master #(
    parameter int PREAMBLE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  reg_addr,
    input  logic        reg_wen,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    import mdio45_pkg::*;

    localparam int CNT_W = $clog2(MAX_HALF);

    logic [DATA_W-1:0] data_q;
    logic [PRT_W-1:0]  port_q;
    logic [DEV_W-1:0]  dev_q;
    logic [2:0]        op_q;
    logic              rvalid_q;
    logic              busy_q;
    logic [DATA_W-1:0] regnum_q;
    logic [31:0]       cfg_q;

    logic              accept;
    logic              w_op_ok;
    logic              rise, fall;
    logic              eng_active, eng_done, eng_ok;
    logic [DATA_W-1:0] eng_data;

    // Command acceptance decode.
    always_comb begin
        w_op_ok = (reg_wdata[28:26] == OPC_WRITE) || (reg_wdata[28:26] == OPC_READ);
        accept  = reg_wen && (reg_addr == OFS_MGMT) && !busy_q && w_op_ok;
    end

    // Host register updates, command capture and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q   <= '0;
            port_q   <= '0;
            dev_q    <= '0;
            op_q     <= '0;
            rvalid_q <= 1'b0;
            busy_q   <= 1'b0;
            regnum_q <= '0;
            cfg_q    <= '0;
        end else if (busy_q) begin
            if (eng_done) begin
                busy_q <= 1'b0;
                if (op_q == OPC_READ && eng_ok) begin
                    rvalid_q <= 1'b1;
                    data_q   <= eng_data;
                end
            end
        end else if (reg_wen) begin
            if (accept) begin
                data_q   <= reg_wdata[15:0];
                port_q   <= reg_wdata[20:16];
                dev_q    <= reg_wdata[25:21];
                op_q     <= reg_wdata[28:26];
                rvalid_q <= 1'b0;
                busy_q   <= 1'b1;
            end
            if (reg_addr == OFS_ADDR) regnum_q <= reg_wdata[15:0];
            if (reg_addr == OFS_CFG)  cfg_q    <= reg_wdata;
        end
    end

    // Combinational register read.
    always_comb begin
        case (reg_addr)
            OFS_MGMT: reg_rdata = {1'b0, busy_q, rvalid_q, op_q, dev_q, port_q, data_q};
            OFS_ADDR: reg_rdata = {16'h0000, regnum_q};
            OFS_CFG:  reg_rdata = cfg_q;
            default:  reg_rdata = '0;
        endcase
    end

    mdio45_mdc_gen #(.CNT_W(CNT_W)) u_mdc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy_q),
        .div_code (cfg_q[1:0]),
        .mdc      (mdc),
        .rise_o   (rise),
        .fall_o   (fall)
    );

    mdio45_frame_engine #(.PRE_LEN(PREAMBLE_LEN)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .is_read  (op_q == OPC_READ),
        .port     (port_q),
        .dev      (dev_q),
        .reg_num  (regnum_q),
        .wr_data  (data_q),
        .rise     (rise),
        .fall     (fall),
        .mdio_i   (mdio_i),
        .active   (eng_active),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .done     (eng_done),
        .rd_ok    (eng_ok),
        .rd_data  (eng_data)
    );

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !eng_done |=> busy_q); // R5
    AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> !busy_q); // R5
    AST_ENGINE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        eng_active |-> busy_q); // R5
    AST_MDC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> busy_q); // R6
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> $stable(cfg_q) && $stable(regnum_q)); // R9
    AST_RVALID_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !rvalid_q && busy_q); // R4
endmodule

// File: tb/mdio45_master_test.sv
module mdio45_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;

    mdio45_master uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // Behavioural reference state.
    int          cyc = 0;
    bit          m_busy, m_rvalid, m_read;
    int          m_base, m_n;
    logic [15:0] m_data, m_regnum;
    logic [4:0]  m_port, m_dev;
    logic [2:0]  m_op;
    logic [31:0] m_cfg;
    logic [15:0] phy_data = 16'h0;
    bit          phy_ta_bad = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int ratio(input logic [1:0] c);
        case (c)
            2'd0: return 256;
            2'd1: return 64;
            2'd2: return 32;
            default: return 8;
        endcase
    endfunction

    function automatic logic exp_bit(input int fr, input int idx);
        logic [31:0] w;
        if (idx < 32) return 1'b1;
        w = {2'b00, (fr == 0) ? 2'b00 : (m_read ? 2'b11 : 2'b01),
             m_port, m_dev, 2'b10, (fr == 0) ? m_regnum : m_data};
        return w[63 - idx];
    endfunction

    // Reference model update at each rising edge.
    always @(posedge clk) begin
        bit pre;
        cyc++;
        if (!rst_n) begin
            m_busy = 0; m_rvalid = 0; m_read = 0; m_base = 0; m_n = 256;
            m_data = '0; m_regnum = '0; m_port = '0; m_dev = '0; m_op = '0; m_cfg = '0;
        end else begin
            pre = m_busy;
            if (!pre && reg_wen) begin
                if (reg_addr == 4'h0 && (reg_wdata[28:26] == 3'h5 || reg_wdata[28:26] == 3'h7)) begin
                    m_data = reg_wdata[15:0]; m_port = reg_wdata[20:16];
                    m_dev = reg_wdata[25:21]; m_op = reg_wdata[28:26];
                    m_read = (m_op == 3'h7); m_rvalid = 0; m_busy = 1;
                    m_base = cyc; m_n = ratio(m_cfg[1:0]);
                end
                if (reg_addr == 4'h8) m_regnum = reg_wdata[15:0];
                if (reg_addr == 4'hC) m_cfg = reg_wdata;
            end
            if (pre && (cyc - m_base == 128 * m_n)) begin
                m_busy = 0;
                if (m_read && !phy_ta_bad) begin
                    m_rvalid = 1;
                    m_data = phy_data;
                end
            end
        end
    end

    // Per-clock comparison of the pins and stand-in PHY drive.
    always @(negedge clk) begin
        int e, b, fr, idx;
        logic x_mdc, x_oe, x_o;
        if (rst_n) begin
            if (m_busy) begin
                e = cyc - m_base; b = e / m_n; fr = b / 64; idx = b % 64;
                x_mdc = ((e % m_n) >= (m_n / 2));
                x_oe  = !(m_read && fr == 1 && idx >= 46);
                x_o   = exp_bit(fr, idx);
                if (m_read && fr == 1 && idx == 47)      mdio_i = phy_ta_bad;
                else if (m_read && fr == 1 && idx >= 48) mdio_i = phy_data[63 - idx];
                else                                     mdio_i = 1'b1;
            end else begin
                x_mdc = 0; x_oe = 0; x_o = 1; mdio_i = 1'b1;
            end
            check(mdc === x_mdc, "R6 mdc level", {31'b0, mdc}, {31'b0, x_mdc});
            check(mdio_oe === x_oe, "R10 drive enable", {31'b0, mdio_oe}, {31'b0, x_oe});
            if (x_oe) check(mdio_o === x_o, "R3 frame bit", {31'b0, mdio_o}, {31'b0, x_o});
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        while (m_busy) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] cmd(input logic [2:0] op, input logic [4:0] dv,
                                        input logic [4:0] pt, input logic [15:0] dat);
        return {3'b000, op, dv, pt, dat};
    endfunction

    initial begin
        repeat (400000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        rd(4'h0, v); check(v == 0, "R1 mgmt reset", v, 0);
        rd(4'h8, v); check(v == 0, "R1 addr reset", v, 0);
        rd(4'hC, v); check(v == 0, "R1 cfg reset (div 256)", v, 0);
        check(mdc == 0 && mdio_oe == 0 && mdio_o == 1, "R1 pins idle",
              {29'b0, mdc, mdio_oe, mdio_o}, 32'h1);
        // R2: storage registers
        wr(4'h8, 32'hFFFF_1234);
        rd(4'h8, v); check(v == 32'h0000_1234, "R2 addr readback", v, 32'h0000_1234);
        wr(4'hC, 32'hABCD_EF03);
        rd(4'hC, v); check(v == 32'hABCD_EF03, "R2 cfg keeps all bits", v, 32'hABCD_EF03);
        rd(4'h4, v); check(v == 0, "R2 unmapped offset", v, 0);
        // R3 / R5: write command, divide by 8
        wr(4'h0, cmd(3'h5, 5'd3, 5'd5, 16'hBEEF));
        rd(4'h0, v); check(v[30] == 1'b1, "R5 busy after accept", v, 32'h4000_0000);
        // R9: writes while busy have no effect
        wr(4'h8, 32'h5555);
        wr(4'hC, 32'h0);
        wr(4'h0, cmd(3'h7, 5'd9, 5'd9, 16'h0));
        rd(4'h8, v); check(v == 32'h1234, "R9 addr frozen", v, 32'h1234);
        rd(4'hC, v); check(v == 32'hABCD_EF03, "R9 cfg frozen", v, 32'hABCD_EF03);
        rd(4'h0, v); check(v[28:16] == {3'h5, 5'd3, 5'd5}, "R9 command kept", v, {3'b0, 3'h5, 5'd3, 5'd5, 16'h0});
        wait_idle();
        rd(4'h0, v); check(v == cmd(3'h5, 5'd3, 5'd5, 16'hBEEF), "R3 write done, R5 idle", v, cmd(3'h5, 5'd3, 5'd5, 16'hBEEF));
        // R4 / R10: read with good turnaround
        phy_data = 16'hA5C3; phy_ta_bad = 0;
        wr(4'h0, cmd(3'h7, 5'h1E, 5'h1F, 16'h0));
        wait_idle();
        rd(4'h0, v); check(v == (cmd(3'h7, 5'h1E, 5'h1F, 16'hA5C3) | 32'h2000_0000), "R4 read data valid",
                           v, cmd(3'h7, 5'h1E, 5'h1F, 16'hA5C3) | 32'h2000_0000);
        // R7: bad turnaround
        phy_data = 16'h1111; phy_ta_bad = 1;
        wr(4'h0, cmd(3'h7, 5'h02, 5'h04, 16'h7777));
        wait_idle();
        rd(4'h0, v); check(v == cmd(3'h7, 5'h02, 5'h04, 16'h7777), "R7 no read-valid", v, cmd(3'h7, 5'h02, 5'h04, 16'h7777));
        phy_ta_bad = 0;
        // R8: unknown opcode ignored
        wr(4'h0, cmd(3'h2, 5'h11, 5'h12, 16'h4242));
        repeat (20) @(negedge clk);
        rd(4'h0, v); check(v == cmd(3'h7, 5'h02, 5'h04, 16'h7777), "R8 bad opcode ignored", v, cmd(3'h7, 5'h02, 5'h04, 16'h7777));
        check(mdc == 0 && mdio_oe == 0, "R8 no frame", {30'b0, mdc, mdio_oe}, 0);
        // R6: command duration for each remaining divider code
        for (int c = 2; c >= 0; c--) begin
            int cnt;
            wr(4'hC, 32'(c));
            wr(4'h0, cmd(3'h5, 5'(c), 5'd1, 16'h0F0F));
            cnt = 0;
            reg_addr = 4'h0; #1;
            while (reg_rdata[30]) begin
                @(negedge clk); #1; cnt++;
            end
            check(cnt == 128 * ratio(2'(c)), "R6 divider period / R5 busy length", cnt, 128 * ratio(2'(c)));
            @(negedge clk);
        end
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule